// File: doc/BRIEF.md
# Split Descriptor/Data Receive Sink

This block sits on the application side of a receive path where each incoming transaction is delivered as a descriptor followed by a payload stream. The upstream core raises a request together with a 136-bit descriptor. It then opens a data phase and sends 64-bit beats, each marked by a data-valid flag. The sink acknowledges the descriptor and passes it on with a one-cycle valid strobe. It then sends the payload out on a plain valid/ready stream that carries start-of-payload and end-of-payload flags and per-byte enables.

Either side may stall the payload. The upstream stalls by dropping data-valid. The sink stalls by raising its wait output, which it drives from the inverse of downstream ready. The data-phase request stays high through the final beat and may go high again on the very next cycle. For this reason the sink keeps the most recent beat in a single holding register. It releases that beat when the next beat of the same phase is offered, or once the data-phase request has fallen. In the second case the beat leaves as the final one. Reset clears all phase state and drops any partial transaction.

Top module: `rx_desc_sink`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, ack_o, desc_valid_o and beat_valid_o are 0.
- R2: When req_i is seen high and no descriptor is outstanding, ack_o is high for exactly one cycle, in the next cycle. desc_valid_o is high in that same cycle, and desc_o holds the desc_i value present in the cycle the request was taken.
- R3: A new descriptor is acknowledged only after the final beat of every previously acknowledged transaction has been delivered downstream.
- R4: ws_o equals the inverse of beat_ready_i in every cycle. An upstream beat is taken only in a cycle where dfr_i and dv_i are high and ws_o is low.
- R5: Every taken beat appears downstream exactly once and in arrival order, under any mix of upstream valid gaps and downstream ready stalls.
- R6: beat_data_o and beat_be_o carry the upstream beat unchanged. Dword 0 is in bits 31:0. A byte-enable of 8'hFF marks both dwords valid, and 8'h0F marks only the lower dword valid (the final beat of an odd dword count).
- R7: sop_o is 1 on the first beat of each data phase and 0 on all other beats.
- R8: eop_o is 1 only on the final beat of a data phase. That beat is not delivered before dfr_i has dropped after it, and this still holds when dfr_i rises again on the next cycle for another transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Upstream descriptor request, held until acknowledged |
| desc_i | input | 136 | Upstream descriptor |
| ack_o | output | 1 | One-cycle descriptor acknowledge |
| dfr_i | input | 1 | Data-phase request, high through the final beat |
| dv_i | input | 1 | Upstream beat valid |
| ws_o | output | 1 | Wait state toward upstream |
| data_i | input | 64 | Upstream beat, dword 0 in bits 31:0 |
| be_i | input | 8 | Upstream byte enables |
| desc_valid_o | output | 1 | Descriptor valid strobe |
| desc_o | output | 136 | Captured descriptor |
| beat_valid_o | output | 1 | Downstream beat valid |
| beat_ready_i | input | 1 | Downstream ready |
| beat_data_o | output | 64 | Downstream beat data |
| beat_be_o | output | 8 | Downstream byte enables |
| sop_o | output | 1 | First beat of a payload |
| eop_o | output | 1 | Final beat of a payload |

## Verification
Two actions can fall on the same clock edge: the held beat leaving downstream and a new upstream beat taking its place. This covers both a mid-phase replacement and the final beat of one phase leaving while the first beat of the next arrives after a one-cycle gap in dfr_i. The bench provokes this by sweeping payload lengths of one to eight dwords under four stall mixes: none, upstream gaps, ready stalls, and both. It alternates between raising dfr_i on the request cycle and one cycle later. Every delivered beat is compared against a queue the bench builds from the dword count, covering data, byte enables and both boundary flags. A final beat that shows up before its dfr_i drop, or a beat that is lost or duplicated, is reported.

// File: rtl/rx_sink_pkg.sv
package rx_sink_pkg;
  parameter int unsigned BUS_W  = 64;
  parameter int unsigned DESC_W = 136;
  localparam int unsigned BE_W  = BUS_W / 8;

  typedef struct packed {
    logic [BUS_W-1:0] data;
    logic [BE_W-1:0]  be;
    logic             sop;
  } beat_t;
endpackage

// File: rtl/rx_desc_ack.sv
module rx_desc_ack #(
  parameter int unsigned DESC_W = 136,
  parameter int unsigned BAL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic              done_i,
  output logic              ack_o,
  output logic [DESC_W-1:0] desc_o
);
  logic              ack_q;
  logic [BAL_W-1:0]  bal_q;
  logic [DESC_W-1:0] desc_q;
  logic              outstanding;
  logic              launch;

  // acknowledged descriptors minus finished payloads, two's complement
  assign outstanding = ~bal_q[BAL_W-1] & (|bal_q);
  assign launch      = req_i & ~ack_q & ~outstanding;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      bal_q  <= '0;
      desc_q <= '0;
    end else begin
      ack_q <= launch;
      if (launch) desc_q <= desc_i;
      case ({launch, done_i})
        2'b10:   bal_q <= bal_q + BAL_W'(1);
        2'b01:   bal_q <= bal_q - BAL_W'(1);
        default: bal_q <= bal_q;
      endcase
    end
  end

  assign ack_o  = ack_q;
  assign desc_o = desc_q;

  // R2
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  // R2
  ack_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(req_i));
  // R3
  ack_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outstanding && !done_i) |=> !ack_q);
endmodule

// File: rtl/rx_beat_hold.sv
module rx_beat_hold
  import rx_sink_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dfr_i,
  input  logic             dv_i,
  input  logic [BUS_W-1:0] data_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic             ready_i,
  output logic             ws_o,
  output logic             valid_o,
  output logic [BUS_W-1:0] data_o,
  output logic [BE_W-1:0]  be_o,
  output logic             sop_o,
  output logic             eop_o,
  output logic             done_o
);
  beat_t h_q;
  beat_t in_beat;
  logic  h_valid_q, h_last_q, started_q;
  logic  is_last, next_offered, in_fire, out_fire;

  assign ws_o         = ~ready_i;
  // held beat is final once the phase request has dropped behind it
  assign is_last      = h_valid_q & (h_last_q | ~dfr_i);
  assign next_offered = h_valid_q & dfr_i & dv_i;
  assign valid_o      = is_last | next_offered;
  assign in_fire      = dfr_i & dv_i & ready_i;
  assign out_fire     = valid_o & ready_i;
  assign done_o       = out_fire & is_last;

  assign in_beat = '{data: data_i, be: be_i, sop: ~started_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q       <= '0;
      h_valid_q <= 1'b0;
      h_last_q  <= 1'b0;
      started_q <= 1'b0;
    end else begin
      if (in_fire) begin
        h_q       <= in_beat;
        h_valid_q <= 1'b1;
        h_last_q  <= 1'b0;
      end else if (out_fire) begin
        h_valid_q <= 1'b0;
        h_last_q  <= 1'b0;
      end else if (h_valid_q && !dfr_i) begin
        h_last_q  <= 1'b1;
      end
      if (!dfr_i)       started_q <= 1'b0;
      else if (in_fire) started_q <= 1'b1;
    end
  end

  assign data_o = h_q.data;
  assign be_o   = h_q.be;
  assign sop_o  = h_q.sop;
  assign eop_o  = is_last;

  // R5
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && h_valid_q) |-> out_fire);
  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_i && h_valid_q) |=> (h_valid_q && $stable(h_q)));
  // R8
  last_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_valid_q && h_last_q && !out_fire) |=> (h_valid_q && h_last_q));
endmodule

// File: rtl/rx_desc_sink.sv
module rx_desc_sink
  import rx_sink_pkg::*;
#(
  parameter int unsigned BAL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DESC_W-1:0] desc_i,
  output logic              ack_o,
  input  logic              dfr_i,
  input  logic              dv_i,
  output logic              ws_o,
  input  logic [BUS_W-1:0]  data_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              desc_valid_o,
  output logic [DESC_W-1:0] desc_o,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [BUS_W-1:0]  beat_data_o,
  output logic [BE_W-1:0]   beat_be_o,
  output logic              sop_o,
  output logic              eop_o
);
  logic payload_done;
  logic ack;

  rx_desc_ack #(
    .DESC_W (DESC_W),
    .BAL_W  (BAL_W)
  ) i_desc_ack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .desc_i (desc_i),
    .done_i (payload_done),
    .ack_o  (ack),
    .desc_o (desc_o)
  );

  rx_beat_hold i_beat_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dfr_i   (dfr_i),
    .dv_i    (dv_i),
    .data_i  (data_i),
    .be_i    (be_i),
    .ready_i (beat_ready_i),
    .ws_o    (ws_o),
    .valid_o (beat_valid_o),
    .data_o  (beat_data_o),
    .be_o    (beat_be_o),
    .sop_o   (sop_o),
    .eop_o   (eop_o),
    .done_o  (payload_done)
  );

  assign ack_o        = ack;
  assign desc_valid_o = ack;
endmodule

// File: tb/test_rx_desc_sink.sv
module test_rx_desc_sink;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         req_i, dfr_i, dv_i, beat_ready_i;
  logic [135:0] desc_i;
  logic [63:0]  data_i;
  logic [7:0]   be_i;
  logic         ack_o, ws_o, desc_valid_o, beat_valid_o, sop_o, eop_o;
  logic [135:0] desc_o;
  logic [63:0]  beat_data_o;
  logic [7:0]   beat_be_o;

  int checks = 0, errors = 0;
  int cyc = 0, acks_seen = 0, eops_seen = 0, dropped_cnt = 0;
  bit prev_ack = 0, s_ack, s_acc;
  logic [135:0] exp_desc [0:63];
  logic [63:0]  eq_data[$];
  logic [7:0]   eq_be[$];
  bit           eq_sop[$];
  bit           eq_eop[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_sink i_rx_desc_sink (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .desc_i(desc_i), .ack_o(ack_o),
    .dfr_i(dfr_i), .dv_i(dv_i), .ws_o(ws_o), .data_i(data_i), .be_i(be_i),
    .desc_valid_o(desc_valid_o), .desc_o(desc_o), .beat_valid_o(beat_valid_o),
    .beat_ready_i(beat_ready_i), .beat_data_o(beat_data_o), .beat_be_o(beat_be_o),
    .sop_o(sop_o), .eop_o(eop_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [135:0] desc_of(input int t);
    return {8'(t), 64'(t) * 64'h0101_0101_0101_0101, 64'hFEED_0000_0000_0000 | 64'(t)};
  endfunction

  function automatic logic [31:0] dw(input int t, input int k);
    return 32'h5A00_0000 + 32'(t * 256 + k);
  endfunction

  function automatic bit dv_pat(input int mode);
    return (mode == 1 || mode == 3) ? ((cyc * 5 + 1) % 4 != 0) : 1'b1;
  endfunction

  function automatic bit rdy_pat(input int mode);
    return (mode >= 2) ? ((cyc * 7) % 5 >= 2) : 1'b1;
  endfunction

  task automatic step();
    #1;
    chk(ws_o == !beat_ready_i, "R4 ws", 136'(ws_o), 136'(!beat_ready_i));
    if (ack_o) begin
      chk(!prev_ack, "R2 ack width", 136'(prev_ack), 136'(0));
      chk(desc_valid_o, "R2 desc strobe", 136'(desc_valid_o), 136'(1));
      chk(desc_o == exp_desc[acks_seen], "R2 desc value", desc_o, exp_desc[acks_seen]);
      chk(eops_seen >= acks_seen, "R3 ack gate", 136'(eops_seen), 136'(acks_seen));
      acks_seen++;
    end
    prev_ack = ack_o;
    if (beat_valid_o && beat_ready_i) begin
      if (eq_data.size() == 0) begin
        chk(1'b0, "R5 extra beat", 136'(beat_data_o), 136'(0));
      end else begin
        logic [63:0] ed;
        logic [7:0]  eb;
        bit          es, ee;
        ed = eq_data.pop_front(); eb = eq_be.pop_front();
        es = eq_sop.pop_front();  ee = eq_eop.pop_front();
        chk(beat_data_o == ed, "R6 data", 136'(beat_data_o), 136'(ed));
        chk(beat_be_o == eb, "R6 byte enable", 136'(beat_be_o), 136'(eb));
        chk(sop_o == es, "R7 sop", 136'(sop_o), 136'(es));
        chk(eop_o == ee, "R8 eop", 136'(eop_o), 136'(ee));
        if (eop_o) begin
          chk(dropped_cnt > eops_seen, "R8 eop before drop", 136'(dropped_cnt), 136'(eops_seen + 1));
          eops_seen++;
        end
      end
    end
    s_ack = ack_o;
    s_acc = dfr_i & dv_i & !ws_o;
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_tx(input int t, input int n, input int mode, input int stop_after);
    int  nb = (n + 1) / 2;
    int  sent = 0;
    bit  req_done = 0, dropped = 0;
    bit  dfr_on = (t % 2 == 0);
    exp_desc[t] = desc_of(t);
    for (int b = 0; b < nb; b++) begin
      bit two = (2 * b + 1 < n);
      eq_data.push_back({two ? dw(t, 2 * b + 1) : 32'h0, dw(t, 2 * b)});
      eq_be.push_back(two ? 8'hFF : 8'h0F);
      eq_sop.push_back(b == 0);
      eq_eop.push_back(b == nb - 1);
    end
    while ((sent < nb || !req_done) && sent < stop_after) begin
      bit two = (2 * sent + 1 < n);
      req_i  = !req_done;
      desc_i = desc_of(t);
      if (sent == nb && !dropped) begin dropped = 1; dropped_cnt++; end
      dfr_i  = dfr_on && sent < nb;
      dv_i   = dfr_i && dv_pat(mode);
      data_i = (sent < nb) ? {two ? dw(t, 2 * sent + 1) : 32'h0, dw(t, 2 * sent)} : 64'h0;
      be_i   = two ? 8'hFF : 8'h0F;
      beat_ready_i = rdy_pat(mode);
      step();
      if (s_ack) req_done = 1;
      if (s_acc) sent++;
      dfr_on = 1;
    end
    if (sent == nb && !dropped) begin
      req_i = 0; dfr_i = 0; dv_i = 0;
      beat_ready_i = rdy_pat(mode);
      dropped_cnt++;
      step();
    end
  endtask

  task automatic drain(input int expect_eops);
    for (int i = 0; i < 60 && eops_seen < expect_eops; i++) begin
      req_i = 0; dfr_i = 0; dv_i = 0; beat_ready_i = 1;
      step();
    end
    chk(eq_data.size() == 0, "R5 beats lost", 136'(eq_data.size()), 136'(0));
    chk(eops_seen == expect_eops, "R8 eop count", 136'(eops_seen), 136'(expect_eops));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_ni = 0; req_i = 0; dfr_i = 0; dv_i = 0; beat_ready_i = 1;
    desc_i = '0; data_i = '0; be_i = '0;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(!ack_o && !desc_valid_o && !beat_valid_o, "R1 reset",
        136'({ack_o, desc_valid_o, beat_valid_o}), 136'(0));
    rst_ni = 1;
    #1;
    chk(!ack_o && !desc_valid_o && !beat_valid_o, "R1 after release",
        136'({ack_o, desc_valid_o, beat_valid_o}), 136'(0));
    @(negedge clk);

    // sweep dword counts 1..8 under four stall mixes
    for (int mode = 0; mode < 4; mode++)
      for (int n = 1; n <= 8; n++)
        run_tx(mode * 8 + n - 1, n, mode, 1000);
    drain(32);
    chk(acks_seen == 32, "R2 ack count", 136'(acks_seen), 136'(32));

    // R1: reset in mid payload drops the partial transaction
    run_tx(32, 8, 1, 2);
    rst_ni = 0; req_i = 0; dfr_i = 0; dv_i = 0;
    #1;
    chk(!ack_o && !desc_valid_o && !beat_valid_o, "R1 mid reset",
        136'({ack_o, desc_valid_o, beat_valid_o}), 136'(0));
    eq_data.delete(); eq_be.delete(); eq_sop.delete(); eq_eop.delete();
    @(negedge clk);
    rst_ni = 1;
    acks_seen = 33; eops_seen = 33; dropped_cnt = 33; prev_ack = 0;
    @(negedge clk);
    run_tx(33, 5, 2, 1000);
    drain(34);
    chk(acks_seen == 34, "R2 ack after reset", 136'(acks_seen), 136'(34));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule